// File: doc/BRIEF.md
# Fault-Injectable Integer Register File

This block is the integer register file of a small processor core: 32 registers of 32 bits each, two combinational read ports and one write port that updates on the rising clock edge. A read that targets the register being written in the same cycle sees the incoming data, so a dependent instruction needs no extra cycle. Register 0 is a constant zero: it always reads zero and drops any write.

For resilience testing, the block carries a fault-injection port. One strobe names a register, a 32-bit bit mask and a fault kind. The kind is one of four: clear existing stuck-at faults, stuck-at-0, stuck-at-1, or a one-shot flip. Stuck-at faults act on the read path and persist until cleared. A flip inverts the selected stored bits once and can hit any number of bits of one register in one operation.

Top module: `regfile_fi`

## Requirements
- R1: When `wr_en` is high at a rising clock edge and `wr_addr` is non-zero, `wr_data` is stored in that register and can be read on either port from the next cycle on.
- R2: The two read ports are independent and combinational: each returns the register named by its own address in the same cycle.
- R3: When `wr_en` is high and a read address equals a non-zero `wr_addr`, that read port returns `wr_data` in the same cycle, before the edge.
- R4: Reading address 0 returns zero on either port, and a write to address 0 changes nothing.
- R5: With `rst_n` low at a rising edge, every register and every stuck-at fault is cleared.
- R6: A fault strobe (`flt_en` high at an edge) with `flt_kind` 2'b01 forces the masked bits of `flt_reg` to read 0, and with 2'b10 to read 1, from the next cycle on and across later writes. Setting one polarity on a bit removes the other from that bit.
- R7: A fault strobe with `flt_kind` 2'b00 removes both stuck-at faults from the masked bits of `flt_reg`. Reads then show the stored value again.
- R8: A fault strobe with `flt_kind` 2'b11 inverts the masked stored bits of `flt_reg` once, including several bits at a time. The result stays until the next write or flip.
- R9: When a flip and a write target the same register in the same cycle, the register ends up holding `wr_data` with the masked bits inverted.
- R10: Fault strobes of any kind that target register 0 have no effect: it still reads zero.
- R11: Stuck-at faults apply after the same-cycle bypass, so bypassed write data is forced as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| flt_en | input | 1 | Fault command strobe |
| flt_reg | input | 5 | Register targeted by the fault command |
| flt_mask | input | 32 | Bits affected by the fault command |
| flt_kind | input | 2 | 00 clear stuck-at, 01 stuck-at-0, 10 stuck-at-1, 11 flip |

## Verification
Read data is combinational, so a bypassed write is due in the same cycle. A stored write, a stuck-at change and a flip are due in the cycle after the edge that takes them. The bench drives inputs at the falling edge and compares both ports against its behavioural model just before the next rising edge. The model is updated at that edge, so every result is checked in the cycle it is due. Directed cases also compare against fixed hex values worked out from the requirements, which catches errors that the model and the design could share.

// File: rtl/regfile_fi.sv
module regfile_fi #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            flt_en,
  input  logic [AW-1:0]   flt_reg,
  input  logic [XLEN-1:0] flt_mask,
  input  logic [1:0]      flt_kind
);

  localparam logic [1:0] K_CLR  = 2'b00;
  localparam logic [1:0] K_SA0  = 2'b01;
  localparam logic [1:0] K_SA1  = 2'b10;
  localparam logic [1:0] K_FLIP = 2'b11;

  logic [NREGS-1:0][XLEN-1:0] mem;
  logic [NREGS-1:0][XLEN-1:0] sa0;
  logic [NREGS-1:0][XLEN-1:0] sa1;

  logic wr_live, flt_live, flt_on_wr;
  assign wr_live   = wr_en && (wr_addr != '0);
  assign flt_live  = flt_en && (flt_reg != '0);
  assign flt_on_wr = wr_live && (wr_addr == flt_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
      sa0 <= '0;
      sa1 <= '0;
    end else begin
      if (wr_live)
        mem[wr_addr] <= wr_data;
      if (flt_live) begin
        case (flt_kind)
          K_CLR: begin
            sa0[flt_reg] <= sa0[flt_reg] & ~flt_mask;
            sa1[flt_reg] <= sa1[flt_reg] & ~flt_mask;
          end
          K_SA0: begin
            sa0[flt_reg] <= sa0[flt_reg] | flt_mask;
            sa1[flt_reg] <= sa1[flt_reg] & ~flt_mask;
          end
          K_SA1: begin
            sa1[flt_reg] <= sa1[flt_reg] | flt_mask;
            sa0[flt_reg] <= sa0[flt_reg] & ~flt_mask;
          end
          K_FLIP:
            mem[flt_reg] <= (flt_on_wr ? wr_data : mem[flt_reg]) ^ flt_mask;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [XLEN-1:0] read_port(input logic [AW-1:0] a);
    logic [XLEN-1:0] raw;
    raw = (wr_live && wr_addr == a) ? wr_data : mem[a];
    if (a == '0) return '0;
    return (raw & ~sa0[a]) | sa1[a];
  endfunction

  assign rd_data_a = read_port(rd_addr_a);
  assign rd_data_b = read_port(rd_addr_b);

endmodule

module regfile_fi_chk #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              rd_addr_a,
  input logic [XLEN-1:0]            rd_data_a,
  input logic [AW-1:0]              rd_addr_b,
  input logic [XLEN-1:0]            rd_data_b,
  input logic                       wr_en,
  input logic [AW-1:0]              wr_addr,
  input logic [XLEN-1:0]            wr_data,
  input logic                       flt_en,
  input logic [AW-1:0]              flt_reg,
  input logic [XLEN-1:0]            flt_mask,
  input logic [1:0]                 flt_kind,
  input logic [NREGS-1:0][XLEN-1:0] mem,
  input logic [NREGS-1:0][XLEN-1:0] sa0,
  input logic [NREGS-1:0][XLEN-1:0] sa1
);

  AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a == '0 |-> rd_data_a == '0); // R4
  AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_b == '0 |-> rd_data_b == '0); // R4
  AST_REG0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    mem[0] == '0 && sa0[0] == '0 && sa1[0] == '0); // R10
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && wr_addr == rd_addr_a)
      |-> rd_data_a == ((wr_data & ~sa0[rd_addr_a]) | sa1[rd_addr_a])); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && !(flt_en && flt_kind == 2'b11 && flt_reg == wr_addr))
      |=> mem[$past(wr_addr)] == $past(wr_data)); // R1
  AST_FLIP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && flt_kind == 2'b11 && flt_reg != '0 && !(wr_en && wr_addr == flt_reg))
      |=> mem[$past(flt_reg)] == ($past(mem[flt_reg]) ^ $past(flt_mask))); // R8
  AST_FLIP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && flt_kind == 2'b11 && flt_reg != '0 && wr_en && wr_addr == flt_reg)
      |=> mem[$past(flt_reg)] == ($past(wr_data) ^ $past(flt_mask))); // R9
  AST_STUCK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (sa0 & sa1) == '0); // R6
  AST_STUCK_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a != '0 |-> ((rd_data_a & sa0[rd_addr_a]) == '0 &&
                         (rd_data_a & sa1[rd_addr_a]) == sa1[rd_addr_a])); // R6

endmodule

bind regfile_fi regfile_fi_chk #(.NREGS(NREGS), .XLEN(XLEN)) u_chk (.*);

// File: tb/regfile_fi_tb.sv
`timescale 1ns/100ps
module regfile_fi_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0, flt_reg = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0, flt_mask = '0;
  logic        wr_en = 1'b0, flt_en = 1'b0;
  logic [1:0]  flt_kind = 2'b00;

  always #2 clk = ~clk;

  regfile_fi u_dut (.*);

  logic [31:0] m_reg [32];
  logic [31:0] m_s0  [32];
  logic [31:0] m_s1  [32];
  bit          model_ok = 0;
  int          checks = 0, errors = 0;
  string       cur_req = "R5";

  function automatic logic [31:0] model_read(input logic [4:0] a);
    logic [31:0] v;
    if (a == 0) return 32'h0;
    v = (wr_en && wr_addr == a) ? wr_data : m_reg[a];
    return (v & ~m_s0[a]) | m_s1[a];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_reg[i] = 0; m_s0[i] = 0; m_s1[i] = 0; end
      model_ok = 1;
      return;
    end
    if (wr_en && wr_addr != 0) m_reg[wr_addr] = wr_data;
    if (flt_en && flt_reg != 0) begin
      case (flt_kind)
        2'b00: begin m_s0[flt_reg] &= ~flt_mask; m_s1[flt_reg] &= ~flt_mask; end
        2'b01: begin m_s0[flt_reg] |= flt_mask;  m_s1[flt_reg] &= ~flt_mask; end
        2'b10: begin m_s1[flt_reg] |= flt_mask;  m_s0[flt_reg] &= ~flt_mask; end
        default: m_reg[flt_reg] ^= flt_mask;
      endcase
    end
  endtask

  task automatic step();
    #1;
    if (model_ok) begin
      check(cur_req, "port A vs model", rd_data_a, model_read(rd_addr_a));
      check(cur_req, "port B vs model", rd_data_b, model_read(rd_addr_b));
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 0; flt_en = 0;
  endtask

  task automatic lit_a(input string req, input logic [31:0] exp);
    #0.5; check(req, "port A literal", rd_data_a, exp);
  endtask

  task automatic lit_b(input string req, input logic [31:0] exp);
    #0.5; check(req, "port B literal", rd_data_b, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic flt(input logic [4:0] r, input logic [31:0] m, input logic [1:0] k);
    flt_en = 1; flt_reg = r; flt_mask = m; flt_kind = k;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    cur_req = "R5";
    rd_addr_a = 7; rd_addr_b = 31; lit_a("R5", 0); lit_b("R5", 0); step();

    cur_req = "R1";
    wr(5, 32'h1234_5678); step();
    wr(31, 32'hDEAD_BEEF); step();
    rd_addr_a = 5; lit_a("R1", 32'h1234_5678); step();

    cur_req = "R2";
    rd_addr_a = 31; rd_addr_b = 5;
    lit_a("R2", 32'hDEAD_BEEF); lit_b("R2", 32'h1234_5678); step();

    cur_req = "R3";
    wr(9, 32'hCAFE_F00D); rd_addr_a = 9; rd_addr_b = 9;
    lit_a("R3", 32'hCAFE_F00D); lit_b("R3", 32'hCAFE_F00D); step();

    cur_req = "R4";
    wr(0, 32'hFFFF_FFFF); rd_addr_a = 0; lit_a("R4", 0); step();
    rd_addr_b = 0; lit_b("R4", 0); step();

    cur_req = "R6";
    flt(5, 32'h0000_00FF, 2'b01); step();
    rd_addr_a = 5; lit_a("R6", 32'h1234_5600); step();
    wr(5, 32'hFFFF_FFFF); step();
    lit_a("R6", 32'hFFFF_FF00); step();
    flt(5, 32'h0000_000F, 2'b10); step();
    lit_a("R6", 32'hFFFF_FF0F); step();

    cur_req = "R11";
    wr(5, 32'h0000_0000); lit_a("R11", 32'h0000_000F); step();

    cur_req = "R7";
    flt(5, 32'hFFFF_FFFF, 2'b00); step();
    lit_a("R7", 32'h0000_0000); step();

    cur_req = "R8";
    rd_addr_a = 9;
    flt(9, 32'h8000_0001, 2'b11); step();
    lit_a("R8", 32'h4AFE_F00C); step();
    flt(9, 32'h0007_0000, 2'b11); step();
    lit_a("R8", 32'h4AF9_F00C); step(); step();
    lit_a("R8", 32'h4AF9_F00C); step();

    cur_req = "R9";
    wr(12, 32'h0000_FFFF); flt(12, 32'h00FF_00FF, 2'b11); step();
    rd_addr_b = 12; lit_b("R9", 32'h00FF_FF00); step();

    cur_req = "R10";
    rd_addr_a = 0;
    for (int k = 0; k < 4; k++) begin
      flt(0, 32'hFFFF_FFFF, k[1:0]); step();
      lit_a("R10", 0);
    end
    step();

    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      rd_addr_a = 5'($urandom); rd_addr_b = 5'($urandom);
      if ($urandom_range(0, 3) != 0) wr(5'($urandom), $urandom);
      if ($urandom_range(0, 5) == 0)
        flt(5'($urandom), 32'(1) << $urandom_range(0, 31) | (($urandom_range(0, 1) == 1) ? 32'(1) << $urandom_range(0, 31) : 32'h0), 2'($urandom));
      if ($urandom_range(0, 7) == 0) rd_addr_a = wr_addr;
      step();
    end

    cur_req = "R5";
    rst_n = 0; step(); rst_n = 1;
    for (int i = 1; i < 32; i++) begin
      rd_addr_a = 5'(i); lit_a("R5", 0); step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule